// File: doc/BRIEF.md
# Serial Flash Shared Reset/Hold Pin Controller

This block sits beside the shift logic of a serial-flash slave and decides what the shared reset/hold input pin means at any moment. It samples chip select, the serial clock and the shared pin into a fast system clock domain. After power-on the pin is an active-low reset. Once the command decoder pulses a one-cycle enable strobe, the pin becomes a pause input and stays one until the power-on reset is applied again.

When the pin serves as a pause input, a low level moves the slave into a held state, but only while the serial clock is low and chip select is active. A level change that arrives while the clock is high takes effect once the clock has returned low. While held, the block freezes its serial bit counter, ignores clock edges and withdraws the data-out enable. Releasing the pin resumes the sequence exactly where it stopped. If chip select is dropped during a pause, the block discards the transfer and signals a standby abort.

Top module: `flash_hold_ctrl`

## Requirements
- R1: After power-on reset the pin acts as a reset: while the synchronized pin is low, `dev_rst` is 1 and `bit_cnt` is held at 0. With the pin high, `dev_rst` is 0.
- R2: A one-cycle pulse on `hold_en_stb` switches the pin into its pause role. From then on a low pin never raises `dev_rst`.
- R3: The pause role persists through any activity on the pin and chip select. Only `por_n` low clears it, which restores reset behaviour.
- R4: With the pause role set, chip select low and the serial clock low, a low pin raises `shift_pause`.
- R5: A pin fall while the serial clock is high does not raise `shift_pause` until the clock has gone low.
- R6: A pin rise while the clock is low drops `shift_pause`. A pin rise while the clock is high leaves `shift_pause` at 1 until the clock goes low.
- R7: `so_oe` equals `so_drive_req` while chip select is low, the block is not paused and it is not in reset. `so_oe` is 0 whenever `shift_pause` is 1.
- R8: While paused, rising serial clock edges do not change `bit_cnt`. After release, counting continues from the frozen value.
- R9: Chip select going high while paused produces exactly one single-cycle `standby_abort` pulse, drops `shift_pause`, and clears `bit_cnt` to 0.
- R10: With chip select high, a low pin never raises `shift_pause`.
- R11: `bit_cnt` counts rising serial clock edges modulo 2^CNT_W while chip select is low, and it is cleared while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| cs_n_pin | input | 1 | Chip select pin, active low, asynchronous |
| sck_pin | input | 1 | Serial clock pin, asynchronous |
| rsthold_pin | input | 1 | Shared reset/pause pin, active low, asynchronous |
| hold_en_stb | input | 1 | One-cycle strobe from the command decoder that selects the pause role |
| so_drive_req | input | 1 | Shift logic requests to drive data out |
| shift_pause | output | 1 | Pause qualifier for the shift and bit-count logic |
| so_oe | output | 1 | Data-out driver enable |
| dev_rst | output | 1 | Device reset, high while the pin asserts reset in reset role |
| standby_abort | output | 1 | Single-cycle pulse: transfer abandoned during a pause |
| bit_cnt | output | CNT_W | Serial bit position within the current byte |

## Verification
The bench changes the shared pin both while the serial clock is low and while it is high. A design that reacts to the pin without checking the clock would pause or resume half a bit early, and the deferred-entry and deferred-exit checks would catch it. Clock pulses are sent during a pause, and counting is checked after release. A counter that is not gated, or one that is restarted, would show the wrong bit position. The bench also drops chip select during a pause and counts the abort pulses, so a missing, repeated or stretched pulse is caught. A pin pulled low after the enable strobe and again after a power cycle shows whether the role flag can be cleared by the wrong reset, or fails to be cleared by the right one.

// File: rtl/flash_hold_pkg.sv
package flash_hold_pkg;

  typedef enum logic [0:0] {
    HS_RUN  = 1'b0,
    HS_HELD = 1'b1
  } hold_st_t;

  // Pause may begin only with pause role, chip select active, clock low, pin low
  function automatic logic pause_entry_ok(input logic role_hold, input logic cs_n,
                                          input logic sck, input logic pin);
    return role_hold && !cs_n && !sck && !pin;
  endfunction

  // Pause releases on a high pin, but only once the clock is low
  function automatic logic pause_exit_ok(input logic sck, input logic pin);
    return pin && !sck;
  endfunction

endpackage

// File: rtl/fh_sync.sv
module fh_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/fh_role_flag.sv
module fh_role_flag (
  input  logic clk,
  input  logic por_n,
  input  logic set_stb,
  output logic role_hold
);

  logic role_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       role_q <= 1'b0;
    else if (set_stb) role_q <= 1'b1;
  end

  assign role_hold = role_q;

  // R3
  role_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    role_q |=> role_q);

endmodule

// File: rtl/fh_hold_fsm.sv
module fh_hold_fsm
  import flash_hold_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic role_hold,
  input  logic cs_n_s,
  input  logic sck_s,
  input  logic pin_s,
  output logic paused,
  output logic abort_pulse
);

  hold_st_t st_q, st_d;
  logic     abort_q, abort_d;
  logic     enter_ev, leave_ev, drop_ev;

  // Named events for the assertions
  assign enter_ev = (st_q == HS_RUN) && pause_entry_ok(role_hold, cs_n_s, sck_s, pin_s);
  assign drop_ev  = (st_q == HS_HELD) && cs_n_s;
  assign leave_ev = (st_q == HS_HELD) && !cs_n_s && pause_exit_ok(sck_s, pin_s);

  always_comb begin
    st_d    = st_q;
    abort_d = 1'b0;
    unique case (st_q)
      HS_RUN:  if (enter_ev) st_d = HS_HELD;
      HS_HELD: begin
        if (drop_ev) begin
          st_d    = HS_RUN;
          abort_d = 1'b1;
        end else if (leave_ev || !role_hold) begin
          st_d = HS_RUN;
        end
      end
      default: st_d = HS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= HS_RUN;
      abort_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      abort_q <= abort_d;
    end
  end

  assign paused      = (st_q == HS_HELD);
  assign abort_pulse = abort_q;

  // R4
  entry_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(paused) |-> $past(!sck_s && !cs_n_s && !pin_s && role_hold));

  // R6
  exit_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(paused) && !abort_q) |-> $past(!sck_s && pin_s));

  // R9
  abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |-> (!paused && $past(paused) && $past(cs_n_s)));

  // R9
  abort_no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |=> !abort_q);

endmodule

// File: rtl/fh_bit_counter.sv
module fh_bit_counter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck_s,
  input  logic             cs_n_s,
  input  logic             paused,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);

  logic             sck_d;
  logic             sck_rise;
  logic             step_ev;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return v + 1'b1;
  endfunction

  assign sck_rise = sck_s && !sck_d;
  assign step_ev  = sck_rise && !paused && !cs_n_s && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      cnt_q <= '0;
    end else begin
      sck_d <= sck_s;
      if (clr || cs_n_s) cnt_q <= '0;
      else if (step_ev)  cnt_q <= bump(cnt_q);
    end
  end

  assign cnt = cnt_q;

  // R8
  frozen_when_paused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && !cs_n_s && !clr) |=> $stable(cnt_q));

  // R11
  clear_on_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> (cnt_q == '0));

endmodule

// File: rtl/flash_hold_ctrl.sv
module flash_hold_ctrl #(
  parameter int CNT_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             cs_n_pin,
  input  logic             sck_pin,
  input  logic             rsthold_pin,
  input  logic             hold_en_stb,
  input  logic             so_drive_req,
  output logic             shift_pause,
  output logic             so_oe,
  output logic             dev_rst,
  output logic             standby_abort,
  output logic [CNT_W-1:0] bit_cnt
);

  localparam int          PIN_N   = 3;
  localparam logic [PIN_N-1:0] PIN_IDLE = 3'b101; // {pin, sck, cs_n}

  logic [PIN_N-1:0] raw_bus, sync_bus;
  logic cs_n_s, sck_s, pin_s;
  logic role_hold;
  logic paused;
  logic dev_rst_q;

  assign raw_bus = {rsthold_pin, sck_pin, cs_n_pin};

  fh_sync #(
    .WIDTH  (PIN_N),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk     (clk),
    .rst_n   (por_n),
    .async_in(raw_bus),
    .sync_out(sync_bus)
  );

  assign cs_n_s = sync_bus[0];
  assign sck_s  = sync_bus[1];
  assign pin_s  = sync_bus[2];

  fh_role_flag u_role (
    .clk      (clk),
    .por_n    (por_n),
    .set_stb  (hold_en_stb),
    .role_hold(role_hold)
  );

  // Reset role: a low pin resets the device
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) dev_rst_q <= 1'b0;
    else        dev_rst_q <= !role_hold && !pin_s;
  end

  fh_hold_fsm u_fsm (
    .clk        (clk),
    .rst_n      (por_n),
    .role_hold  (role_hold),
    .cs_n_s     (cs_n_s),
    .sck_s      (sck_s),
    .pin_s      (pin_s),
    .paused     (paused),
    .abort_pulse(standby_abort)
  );

  fh_bit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (por_n),
    .sck_s (sck_s),
    .cs_n_s(cs_n_s),
    .paused(paused),
    .clr   (dev_rst_q),
    .cnt   (bit_cnt)
  );

  assign shift_pause = paused;
  assign dev_rst     = dev_rst_q;
  assign so_oe       = so_drive_req && !cs_n_s && !paused && !dev_rst_q;

  // R2
  no_reset_in_hold_role_chk: assert property (@(posedge clk) disable iff (!por_n)
    (role_hold && $past(role_hold)) |-> !dev_rst_q);

  // R7
  so_released_chk: assert property (@(posedge clk) disable iff (!por_n)
    paused |-> !so_oe);

  // R10
  no_pause_deselected_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(paused) |-> $past(!cs_n_s));

endmodule

// File: tb/flash_hold_ctrl_test.sv
module flash_hold_ctrl_test;

  localparam int CNT_W = 3;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic cs_n_pin = 1'b1;
  logic sck_pin = 1'b0;
  logic rsthold_pin = 1'b1;
  logic hold_en_stb = 1'b0;
  logic so_drive_req = 1'b0;
  logic shift_pause, so_oe, dev_rst, standby_abort;
  logic [CNT_W-1:0] bit_cnt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flash_hold_ctrl #(.CNT_W(CNT_W), .SYNC_STAGES(2)) uut (
    .clk          (clk),
    .por_n        (por_n),
    .cs_n_pin     (cs_n_pin),
    .sck_pin      (sck_pin),
    .rsthold_pin  (rsthold_pin),
    .hold_en_stb  (hold_en_stb),
    .so_drive_req (so_drive_req),
    .shift_pause  (shift_pause),
    .so_oe        (so_oe),
    .dev_rst      (dev_rst),
    .standby_abort(standby_abort),
    .bit_cnt      (bit_cnt)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic sck_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      sck_pin = 1'b1; wait_clk(5);
      sck_pin = 1'b0; wait_clk(5);
    end
  endtask

  task automatic power_on();
    por_n = 1'b0; cs_n_pin = 1'b1; sck_pin = 1'b0; rsthold_pin = 1'b1;
    hold_en_stb = 1'b0; so_drive_req = 1'b0;
    wait_clk(4);
    por_n = 1'b1;
    wait_clk(4);
  endtask

  task automatic t_reset_role();
    check("R1", "pause after power-on", shift_pause, 0);
    check("R1", "dev_rst after power-on", dev_rst, 0);
    check("R1", "bit_cnt after power-on", bit_cnt, 0);
    check("R1", "abort after power-on", standby_abort, 0);
    cs_n_pin = 1'b0; wait_clk(4);
    sck_pulses(3);
    check("R11", "count of three edges", bit_cnt, 3);
    so_drive_req = 1'b1; wait_clk(2);
    check("R7", "so_oe follows request", so_oe, 1);
    rsthold_pin = 1'b0; wait_clk(6);
    check("R1", "dev_rst on low pin", dev_rst, 1);
    check("R1", "bit_cnt cleared by reset", bit_cnt, 0);
    check("R1", "no pause in reset role", shift_pause, 0);
    rsthold_pin = 1'b1; wait_clk(6);
    check("R1", "dev_rst released", dev_rst, 0);
    so_drive_req = 1'b0;
    cs_n_pin = 1'b1; wait_clk(6);
    check("R11", "cleared when deselected", bit_cnt, 0);
  endtask

  task automatic t_wrap();
    cs_n_pin = 1'b0; wait_clk(4);
    sck_pulses(10);
    check("R11", "count wraps modulo 8", bit_cnt, 2);
    cs_n_pin = 1'b1; wait_clk(6);
  endtask

  task automatic t_enable();
    @(negedge clk) hold_en_stb = 1'b1;
    @(negedge clk) hold_en_stb = 1'b0;
    wait_clk(2);
    rsthold_pin = 1'b0; wait_clk(8);
    check("R2", "no dev_rst in pause role", dev_rst, 0);
    check("R10", "no pause with chip select high", shift_pause, 0);
    rsthold_pin = 1'b1; wait_clk(6);
  endtask

  task automatic t_hold_clock_low();
    cs_n_pin = 1'b0; wait_clk(4);
    so_drive_req = 1'b1;
    sck_pulses(3);
    rsthold_pin = 1'b0; wait_clk(6);
    check("R4", "pause with clock low", shift_pause, 1);
    check("R7", "so_oe released in pause", so_oe, 0);
    sck_pulses(4);
    check("R8", "count frozen in pause", bit_cnt, 3);
    rsthold_pin = 1'b1; wait_clk(6);
    check("R6", "release with clock low", shift_pause, 0);
    check("R7", "so_oe back after release", so_oe, 1);
    sck_pulses(2);
    check("R8", "count resumes from frozen value", bit_cnt, 5);
    so_drive_req = 1'b0;
    cs_n_pin = 1'b1; wait_clk(6);
  endtask

  task automatic t_hold_clock_high();
    cs_n_pin = 1'b0; wait_clk(4);
    sck_pulses(1);
    sck_pin = 1'b1; wait_clk(4);
    rsthold_pin = 1'b0; wait_clk(8);
    check("R5", "entry deferred while clock high", shift_pause, 0);
    sck_pin = 1'b0; wait_clk(6);
    check("R5", "entry once clock low", shift_pause, 1);
    sck_pin = 1'b1; wait_clk(6);
    rsthold_pin = 1'b1; wait_clk(8);
    check("R6", "exit deferred while clock high", shift_pause, 1);
    sck_pin = 1'b0; wait_clk(6);
    check("R6", "exit once clock low", shift_pause, 0);
    check("R8", "held edge not counted", bit_cnt, 2);
    cs_n_pin = 1'b1; wait_clk(6);
  endtask

  task automatic t_abort();
    int pulses = 0;
    cs_n_pin = 1'b0; wait_clk(4);
    sck_pulses(2);
    rsthold_pin = 1'b0; wait_clk(6);
    check("R9", "paused before deselect", shift_pause, 1);
    cs_n_pin = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (standby_abort) pulses++;
    end
    check("R9", "abort pulse count", pulses, 1);
    check("R9", "pause dropped on deselect", shift_pause, 0);
    check("R9", "count cleared on abort", bit_cnt, 0);
    rsthold_pin = 1'b1; wait_clk(6);
    cs_n_pin = 1'b0; wait_clk(4);
    sck_pulses(1);
    check("R9", "new sequence counts from zero", bit_cnt, 1);
    cs_n_pin = 1'b1; wait_clk(6);
  endtask

  task automatic t_power_cycle();
    for (int i = 0; i < 3; i++) begin
      rsthold_pin = 1'b0; wait_clk(6);
      check("R3", "role kept across pin lows", dev_rst, 0);
      rsthold_pin = 1'b1; wait_clk(4);
    end
    power_on();
    rsthold_pin = 1'b0; wait_clk(6);
    check("R3", "reset role back after power cycle", dev_rst, 1);
    cs_n_pin = 1'b0; wait_clk(6);
    check("R3", "no pause after power cycle", shift_pause, 0);
    rsthold_pin = 1'b1; cs_n_pin = 1'b1; wait_clk(6);
    check("R3", "dev_rst released after power cycle", dev_rst, 0);
  endtask

  initial begin
    power_on();
    t_reset_role();
    t_wrap();
    t_enable();
    t_hold_clock_low();
    t_hold_clock_high();
    t_abort();
    t_power_cycle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule